// File: doc/BRIEF.md
# Vector Halfword Inequality Compare Unit

This execution unit takes two 128-bit operand vectors, splits each into eight 16-bit lanes, and checks the lanes pairwise for inequality. Each lane of the registered result mask is all ones where the operands differ and all zeros where they match. The unit also reduces the lane results into two summary flags: one set when every lane differs, and one set when no lane differs. When the record flag of the issued operation is set, it writes these flags as a 4-bit condition value.

A pipeline issues one operation per strobe. The strobe carries the record flag, the 5-bit destination field and the vector-facility enable bit. When the facility is off, the unit raises an unavailable pulse and produces no result and no condition write. All outputs are registered and appear one clock after the issue.

Top module: `vec_hneq_cmp`

## Requirements
- R1: Lane k (k = 0..7) occupies bits [127-16k : 112-16k] of each vector. Lane 0 is bits 127:112. The result lane is 16'hFFFF when the two operand lanes differ and 16'h0000 when they are equal.
- R2: Bit 3 of the condition value is 1 exactly when all eight lanes differ.
- R3: Bit 1 of the condition value is 1 exactly when all eight lanes are equal. Bits 2 and 0 are always 0.
- R4: An enabled issue with the record flag at 1 pulses the condition write strobe for one cycle, carrying the value {allDiffer, 0, allEqual, 0}. With the record flag at 0, the strobe stays low.
- R5: An issue with the facility enable at 0 pulses the unavailable flag for one cycle. For that issue, neither the result-valid strobe nor the condition write strobe rises, and the mask keeps its previous value.
- R6: The result-valid strobe, mask and condition write appear exactly one clock after an enabled issue. Without an issue, the result-valid strobe and the condition write strobe stay low.
- R7: The destination index output equals the 5-bit destination field plus 32.
- R8: A synchronous active-high reset clears all strobes, the mask, the destination index and the condition value to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | Operation issue strobe |
| recordBit | input | 1 | Request a condition value write |
| vecEnable | input | 1 | Vector facility enabled |
| dstField | input | 5 | Destination register field |
| srcA | input | 128 | First operand vector |
| srcB | input | 128 | Second operand vector |
| resValid | output | 1 | Result valid, one cycle after issue |
| resMask | output | 128 | Per-lane inequality mask |
| dstIndex | output | 6 | Destination register index (field + 32) |
| condWrite | output | 1 | Condition value write strobe |
| condValue | output | 4 | {allDiffer, 0, allEqual, 0} |
| unavailExc | output | 1 | Vector-unavailable exception pulse |

## Verification
The bench targets lane ordering with a single differing lane at each end of the vector. A design with the lanes reversed or shifted would set the wrong 16-bit slice. It drives all-different, all-equal and mixed vectors so that each summary bit is checked at both values. A swapped or inverted reduction would show up as a wrong condition nibble. It issues with the facility disabled after a valid result, which catches a design that still writes the mask or pulses the strobes. Record-off and idle cycles catch a condition write that leaks through.

// File: rtl/vhc_pkg.sv
package vhc_pkg;
  typedef struct packed {
    logic computeEn;
    logic recordEn;
    logic raiseExc;
  } ctrlStrobes_t;
endpackage

// File: rtl/vhc_ctrl.sv
module vhc_ctrl
  import vhc_pkg::*;
(
  input  logic         issueValid,
  input  logic         recordBit,
  input  logic         vecEnable,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.computeEn = issueValid && vecEnable;
    strobes.recordEn  = issueValid && vecEnable && recordBit;
    strobes.raiseExc  = issueValid && !vecEnable;
  end
endmodule

// File: rtl/vhc_datapath.sv
module vhc_datapath
  import vhc_pkg::*;
#(
  parameter int LANE_W   = 16,
  parameter int LANES    = 8,
  parameter int FIELD_W  = 5,
  parameter int REG_BASE = 32,
  localparam int VEC_W   = LANE_W * LANES,
  localparam int IDX_W   = FIELD_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrlStrobes_t       strobes,
  input  logic [FIELD_W-1:0] dstField,
  input  logic [VEC_W-1:0]   srcA,
  input  logic [VEC_W-1:0]   srcB,
  output logic               resValid,
  output logic [VEC_W-1:0]   resMask,
  output logic [IDX_W-1:0]   dstIndex,
  output logic               condWrite,
  output logic [3:0]         condValue,
  output logic               unavailExc
);
  logic [LANES-1:0] laneNe;
  logic [VEC_W-1:0] nextMask;
  logic allDiffer, allEqual;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int HI = VEC_W - 1 - k * LANE_W;
    assign laneNe[k] = srcA[HI -: LANE_W] != srcB[HI -: LANE_W];
    assign nextMask[HI -: LANE_W] = {LANE_W{laneNe[k]}};
  end

  assign allDiffer = &laneNe;
  assign allEqual  = ~|laneNe;

  always_ff @(posedge clk) begin
    if (rst) begin
      resValid   <= 1'b0;
      condWrite  <= 1'b0;
      unavailExc <= 1'b0;
      resMask    <= '0;
      dstIndex   <= '0;
      condValue  <= '0;
    end else begin
      resValid   <= strobes.computeEn;
      condWrite  <= strobes.recordEn;
      unavailExc <= strobes.raiseExc;
      if (strobes.computeEn) begin
        resMask  <= nextMask;
        dstIndex <= IDX_W'(dstField) + IDX_W'(REG_BASE);
      end
      if (strobes.recordEn)
        condValue <= {allDiffer, 1'b0, allEqual, 1'b0};
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_laneChk
    localparam int HI = VEC_W - 1 - k * LANE_W;
    // R1
    lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
      resValid |-> (resMask[HI -: LANE_W] == '0 || resMask[HI -: LANE_W] == '1));
  end

  // R3
  cond_zero_bits_chk: assert property (@(posedge clk) disable iff (rst)
    condWrite |-> (condValue[2] == 1'b0 && condValue[0] == 1'b0));

  // R2
  cond_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    condWrite |-> !(condValue[3] && condValue[1]));

  // R4
  cond_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    condWrite |-> resValid);

  // R5
  exc_holds_mask_chk: assert property (@(posedge clk) disable iff (rst)
    unavailExc |-> $stable(resMask));
endmodule

// File: rtl/vec_hneq_cmp.sv
module vec_hneq_cmp
  import vhc_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         issueValid,
  input  logic         recordBit,
  input  logic         vecEnable,
  input  logic [4:0]   dstField,
  input  logic [127:0] srcA,
  input  logic [127:0] srcB,
  output logic         resValid,
  output logic [127:0] resMask,
  output logic [5:0]   dstIndex,
  output logic         condWrite,
  output logic [3:0]   condValue,
  output logic         unavailExc
);
  ctrlStrobes_t strobes;

  vhc_ctrl u_ctrl (
    .issueValid (issueValid),
    .recordBit  (recordBit),
    .vecEnable  (vecEnable),
    .strobes    (strobes)
  );

  vhc_datapath #(
    .LANE_W   (16),
    .LANES    (8),
    .FIELD_W  (5),
    .REG_BASE (32)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .dstField   (dstField),
    .srcA       (srcA),
    .srcB       (srcB),
    .resValid   (resValid),
    .resMask    (resMask),
    .dstIndex   (dstIndex),
    .condWrite  (condWrite),
    .condValue  (condValue),
    .unavailExc (unavailExc)
  );

  // R6
  valid_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
    resValid |-> $past(issueValid && vecEnable));

  // R5
  exc_no_result_chk: assert property (@(posedge clk) disable iff (rst)
    unavailExc |-> (!resValid && !condWrite));

  // R5
  exc_needs_issue_chk: assert property (@(posedge clk) disable iff (rst)
    unavailExc |-> $past(issueValid && !vecEnable));
endmodule

// File: tb/vec_hneq_cmp_bench.sv
`timescale 1ns/1ps
module vec_hneq_cmp_bench;
  logic clk = 1'b0;
  logic rst, issueValid, recordBit, vecEnable;
  logic [4:0] dstField;
  logic [127:0] srcA, srcB;
  logic resValid, condWrite, unavailExc;
  logic [127:0] resMask;
  logic [5:0] dstIndex;
  logic [3:0] condValue;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vec_hneq_cmp u_vec_hneq_cmp (
    .clk(clk), .rst(rst), .issueValid(issueValid), .recordBit(recordBit),
    .vecEnable(vecEnable), .dstField(dstField), .srcA(srcA), .srcB(srcB),
    .resValid(resValid), .resMask(resMask), .dstIndex(dstIndex),
    .condWrite(condWrite), .condValue(condValue), .unavailExc(unavailExc)
  );

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] refMask(logic [127:0] a, logic [127:0] b);
    logic [127:0] m = '0;
    for (int k = 0; k < 8; k++)
      if (a[127-16*k -: 16] != b[127-16*k -: 16]) m[127-16*k -: 16] = 16'hFFFF;
    return m;
  endfunction

  function automatic logic [3:0] refCond(logic [127:0] a, logic [127:0] b);
    int diffs = 0;
    for (int k = 0; k < 8; k++)
      if (a[127-16*k -: 16] != b[127-16*k -: 16]) diffs++;
    return {diffs == 8, 1'b0, diffs == 0, 1'b0};
  endfunction

  // Drive at negedge, one posedge, then sample at the following negedge.
  task automatic doIssue(logic [127:0] a, logic [127:0] b, logic rec, logic en, logic [4:0] f);
    @(negedge clk);
    srcA = a; srcB = b; recordBit = rec; vecEnable = en; dstField = f; issueValid = 1'b1;
    @(negedge clk);
    issueValid = 1'b0;
  endtask

  task automatic tReset();
    rst = 1'b1; issueValid = 1'b0; recordBit = 1'b0; vecEnable = 1'b1;
    dstField = '0; srcA = '0; srcB = '0;
    repeat (3) @(negedge clk);
    chk("R8 valid", 128'(resValid), 0);
    chk("R8 condWrite", 128'(condWrite), 0);
    chk("R8 exc", 128'(unavailExc), 0);
    chk("R8 mask", resMask, 0);
    chk("R8 index", 128'(dstIndex), 0);
    chk("R8 cond", 128'(condValue), 0);
    rst = 1'b0;
  endtask

  task automatic tEdgeLanes();
    logic [127:0] a = 128'h0123_4567_89AB_CDEF_0011_2233_4455_6677;
    logic [127:0] b = a ^ {16'h0001, 112'h0};
    doIssue(a, b, 1'b1, 1'b1, 5'd3);
    chk("R1 lane0 mask", resMask, {16'hFFFF, 112'h0});
    chk("R6 valid", 128'(resValid), 1);
    chk("R3 cond mixed", 128'(condValue), 128'(refCond(a, b)));
    b = a ^ 128'h8000;
    doIssue(a, b, 1'b1, 1'b1, 5'd3);
    chk("R1 lane7 mask", resMask, {112'h0, 16'hFFFF});
  endtask

  task automatic tAllDiffer();
    logic [127:0] a = {8{16'hA5A5}};
    logic [127:0] b = {8{16'h5A5A}};
    doIssue(a, b, 1'b1, 1'b1, 5'd0);
    chk("R1 all differ mask", resMask, '1);
    chk("R2 cond all differ", 128'(condValue), 128'(4'b1000));
    chk("R4 write", 128'(condWrite), 1);
    chk("R7 index base", 128'(dstIndex), 32);
  endtask

  task automatic tAllEqual();
    logic [127:0] a = 128'hDEAD_BEEF_0000_FFFF_1234_8000_0001_7FFF;
    doIssue(a, a, 1'b1, 1'b1, 5'd31);
    chk("R1 all equal mask", resMask, '0);
    chk("R3 cond all equal", 128'(condValue), 128'(4'b0010));
    chk("R7 index top", 128'(dstIndex), 63);
  endtask

  task automatic tPattern();
    logic [127:0] a = 128'h1111_2222_3333_4444_5555_6666_7777_8888;
    logic [127:0] b = 128'h1111_2223_3333_4440_5555_6666_F777_8888;
    doIssue(a, b, 1'b1, 1'b1, 5'd17);
    chk("R1 pattern mask", resMask, refMask(a, b));
    chk("R2 R3 cond pattern", 128'(condValue), 128'(refCond(a, b)));
    chk("R7 index mid", 128'(dstIndex), 49);
  endtask

  task automatic tNoRecord();
    logic [127:0] a = {8{16'h0F0F}};
    doIssue(a, '0, 1'b0, 1'b1, 5'd5);
    chk("R4 no write", 128'(condWrite), 0);
    chk("R4 valid without record", 128'(resValid), 1);
    chk("R4 cond held", 128'(condValue), 128'(refCond(128'h1111_2222_3333_4444_5555_6666_7777_8888,
                                                        128'h1111_2223_3333_4440_5555_6666_F777_8888)));
  endtask

  task automatic tDisabled();
    logic [127:0] prevMask = resMask;
    doIssue({8{16'h1234}}, ~{8{16'h1234}}, 1'b1, 1'b0, 5'd9);
    chk("R5 exc", 128'(unavailExc), 1);
    chk("R5 no valid", 128'(resValid), 0);
    chk("R5 no write", 128'(condWrite), 0);
    chk("R5 mask held", resMask, prevMask);
    @(negedge clk);
    chk("R5 exc one cycle", 128'(unavailExc), 0);
  endtask

  task automatic tIdle();
    logic [127:0] a = {8{16'h00FF}};
    doIssue(a, a ^ {16'h0, 16'h1, 96'h0}, 1'b1, 1'b1, 5'd2);
    chk("R6 mask after one clock", resMask, {16'h0, 16'hFFFF, 96'h0});
    @(negedge clk);
    chk("R6 valid drops", 128'(resValid), 0);
    chk("R6 write drops", 128'(condWrite), 0);
    repeat (3) @(negedge clk);
    chk("R6 idle valid", 128'(resValid), 0);
  endtask

  initial begin
    tReset();
    tEdgeLanes();
    tAllDiffer();
    tAllEqual();
    tPattern();
    tNoRecord();
    tDisabled();
    tIdle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule